// File: doc/BRIEF.md
# Host Interrupt Status Aggregator

This block gathers interrupt events from three internal sources and reports them to a host through one level interrupt line and a small register port. The sources are two audio voice channels and a MIDI port. Each source pulse sets a sticky pending bit. The interrupt line is raised whenever delivery is armed and at least one bit is pending.

The host handles an interrupt by reading the status register. That single read returns the pending bits together with the armed flag. In the same clock edge it clears the pending bits and disarms delivery. A status word whose low 31 bits are zero tells the host that the interrupt was raised by some other device. Delivery stays blocked until the host writes the re-arm command to the control register. That command must carry both the enable bit and the change-mask bit.

Events that arrive while delivery is disarmed are still collected. A source pulse that lands in the same cycle as a status read is kept for the next read.

Top module: `hirq_aggregator`

## Requirements
- R1: After a synchronous reset, the status register reads 0x0000_0000 and `irq_out` is low; delivery starts disarmed.
- R2: A one-cycle pulse on `src_req[i]` sets the pending bit `i` of the status register, readable from the next cycle on. Bit 0 is voice channel 0, bit 1 is voice channel 1 and bit 2 is MIDI.
- R3: Status bit 31 reads 1 exactly when delivery is armed; bits 30:3 always read 0.
- R4: A read at offset 0x00 returns the current status, then at that clock edge clears every pending bit and disarms delivery.
- R5: A source pulse in the same cycle as a status read leaves its pending bit set after the read.
- R6: A write at offset 0x04 with data bits 0 (enable) and 1 (change-mask) both 1 arms delivery from the next cycle. A write with either bit 0 has no effect.
- R7: `irq_out` is high exactly when delivery is armed and at least one pending bit is set, so it is low in the cycle after a status read.
- R8: A read at any offset other than 0x00 returns 0 and changes no state. A write at any offset other than 0x04 changes no state.
- R9: Pending bits accumulate while delivery is disarmed, without raising `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the offset presented, valid in the strobe cycle |
| src_req | input | 3 | Event pulses: bit 0 voice 0, bit 1 voice 1, bit 2 MIDI |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
Directed sequences handle the cases that need ordering:
- a pulse on each source while delivery is disarmed, which separates collection from delivery;
- re-arm writes with only one of the two command bits, which separates a full command from a partial one;
- a pulse in the very cycle of a status read, which shows whether the clear overrides a new event;
- accesses to unmapped and wrong-direction offsets, which show whether the decode leaks side effects.

A long stretch of seeded random traffic follows. It mixes every access kind with random source pulses. This exposes wrong bit positions, a missing disarm and an interrupt line that lags or leads the state.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    localparam int NUM_SRC   = 3;
    localparam int REG_W     = 32;

    // source positions in the status word
    localparam int SRC_VOICE0 = 0;
    localparam int SRC_VOICE1 = 1;
    localparam int SRC_MIDI   = 2;

    // control command bits
    localparam int CMD_ENA_BIT = 0;
    localparam int CMD_CHG_BIT = 1;

    localparam int RSVD_W = REG_W - 1 - NUM_SRC;

    typedef struct packed {
        logic               armed;
        logic [RSVD_W-1:0]  rsvd;
        logic [NUM_SRC-1:0] pend;
    } status_word_t;

    function automatic logic [REG_W-1:0] pack_status(input logic armed,
                                                     input logic [NUM_SRC-1:0] pend);
        status_word_t w;
        w.armed = armed;
        w.rsvd  = '0;
        w.pend  = pend;
        return w;
    endfunction

    function automatic logic is_rearm_cmd(input logic [1:0] cmd);
        return cmd[CMD_ENA_BIT] && cmd[CMD_CHG_BIT];
    endfunction

endpackage

// File: rtl/hirq_pend_bank.sv
module hirq_pend_bank
    import hirq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         consume,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (consume)
                pend[i] <= req[i];          // event racing the read survives
            else if (req[i])
                pend[i] <= 1'b1;
        end

        AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
            req[i] |=> pend[i]);                                        // R2
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (consume && !req[i]) |=> !pend[i]);                         // R4
        AST_RACE_KEPT: assert property (@(posedge clk) disable iff (rst)
            (consume && req[i]) |=> pend[i]);                           // R5
        AST_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!consume && !req[i]) |=> $stable(pend[i]));                // R9
    end

endmodule

// File: rtl/hirq_arm_ctrl.sv
module hirq_arm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic consume,
    input  logic rearm,
    output logic armed
);

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (rearm)
            armed <= 1'b1;
        else if (consume)
            armed <= 1'b0;
    end

    AST_DISARM_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (consume && !rearm) |=> !armed);                                // R4
    AST_ARM_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (!armed && !rearm) |=> !armed);                                 // R6

endmodule

// File: rtl/hirq_aggregator.sv
module hirq_aggregator
    import hirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h04
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               irq_out
);

    logic               stat_rd;
    logic               rearm;
    logic               armed;
    logic [NUM_SRC-1:0] pend;
    logic               unused_wbits;

    assign stat_rd      = reg_rd && (reg_addr == STAT_OFS);
    assign rearm        = reg_wr && (reg_addr == CTRL_OFS) && is_rearm_cmd(reg_wdata[1:0]);
    assign unused_wbits = ^reg_wdata[REG_W-1:2];

    hirq_pend_bank #(.N(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (src_req),
        .consume (stat_rd),
        .pend    (pend)
    );

    hirq_arm_ctrl u_arm (
        .clk     (clk),
        .rst     (rst),
        .consume (stat_rd),
        .rearm   (rearm),
        .armed   (armed)
    );

    always_comb begin
        reg_rdata = '0;
        if (stat_rd)
            reg_rdata = pack_status(armed, pend);
    end

    assign irq_out = armed && (|pend);

    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !reg_wr) |=> !irq_out);                             // R7
    AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        (!irq_out && !rearm && src_req == '0) |=> !irq_out);            // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (reg_rdata[REG_W-2:NUM_SRC] == '0));                 // R3

endmodule

// File: tb/test_hirq_aggregator.sv
module test_hirq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  src_req = '0;
    logic        irq_out;

    int total = 0;
    int bad   = 0;

    // bench model
    logic       m_arm  = 1'b0;
    logic [2:0] m_pend = '0;

    always #10 clk = ~clk;

    hirq_aggregator i_hirq_aggregator (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_req(src_req), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {m_arm, 28'd0, m_pend};
        return 32'd0;
    endfunction

    function automatic logic exp_irq();
        return m_arm && (m_pend != 3'd0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive after negedge, check before posedge, update model
    task automatic cyc(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic [2:0] req, input string tag);
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; src_req = req;
        #1;
        if (rd) chk({tag, " rdata"}, reg_rdata, exp_read(a));
        chk("R7 irq", {31'd0, irq_out}, {31'd0, exp_irq()});
        @(posedge clk);
        if (rd && a == 8'h00) begin
            m_pend = req;
            m_arm  = 1'b0;
        end else
            m_pend = m_pend | req;
        if (wr && a == 8'h04 && wd[1:0] == 2'b11) m_arm = 1'b1;
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; src_req = '0;
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        cyc(0, 0, 8'h00, 0, 3'b000, "R1");
        cyc(1, 0, 8'h00, 0, 3'b000, "R1 status after reset");

        // R9 collect while disarmed, R2 bit positions
        cyc(0, 0, 8'h00, 0, 3'b010, "R2");
        cyc(0, 0, 8'h00, 0, 3'b100, "R9");
        cyc(1, 0, 8'h00, 0, 3'b000, "R9 R2 pending while disarmed");
        cyc(1, 0, 8'h00, 0, 3'b000, "R4 cleared after read");

        // R6 partial commands ignored
        cyc(0, 1, 8'h04, 32'h1, 3'b001, "R6");
        cyc(0, 1, 8'h04, 32'h2, 3'b000, "R6");
        cyc(1, 0, 8'h00, 0, 3'b000, "R6 partial cmd no arm");
        cyc(0, 1, 8'h04, 32'h3, 3'b000, "R6");
        cyc(0, 0, 8'h00, 0, 3'b100, "R7");
        cyc(0, 0, 8'h00, 0, 3'b000, "R7");
        cyc(1, 0, 8'h00, 0, 3'b000, "R3 armed flag in bit31");
        cyc(0, 0, 8'h00, 0, 3'b000, "R7 low after read");

        // R5 pulse racing a read
        cyc(0, 1, 8'h04, 32'hFFFF_FFFF, 3'b010, "R6");
        cyc(1, 0, 8'h00, 0, 3'b001, "R5 read with racing pulse");
        cyc(1, 0, 8'h00, 0, 3'b000, "R5 racing event kept");

        // R8 other offsets have no side effects
        cyc(0, 0, 8'h00, 0, 3'b001, "R8");
        cyc(1, 0, 8'h04, 0, 3'b000, "R8 read ctrl offset");
        cyc(1, 0, 8'h08, 0, 3'b000, "R8 read unmapped offset");
        cyc(0, 1, 8'h00, 32'h3, 3'b000, "R8");
        cyc(0, 1, 8'h0C, 32'h3, 3'b000, "R8");
        cyc(1, 0, 8'h00, 0, 3'b000, "R8 state untouched");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 7);
            logic [2:0] rq = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            case (op)
                0, 1: cyc(1, 0, 8'h00, 0, rq, "R2 R4 random status");
                2:    cyc(0, 1, 8'h04, 32'h3, rq, "R6 random");
                3:    cyc(0, 1, 8'h04, $urandom, rq, "R6 random");
                4:    cyc(1, 0, 8'($urandom_range(1, 15) * 4), 0, rq, "R8 random");
                5:    cyc(0, 1, 8'($urandom_range(2, 15) * 4), $urandom, rq, "R8 random");
                default: cyc(0, 0, 8'h00, 0, rq, "R7 random");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule